// File: doc/BRIEF.md
# Functional unit issue pipeline

This block is the timing skeleton of one execution unit in an in-order core. An operation tag enters on the insert port, moves through a chain of registers whose used length equals the configured operation latency, and appears on the output port. Downstream takes it by raising the accept input. The block does no arithmetic. It only models when a result can appear and when the next operation may enter.

Two effects limit the flow. The first is an issue-rate gate. After an operation enters, further inserts are held off until the configured issue latency has passed. Cycles in which the pipe is frozen do not count toward that latency. The second is back-pressure. When the output holds a valid tag that downstream does not accept, every stage holds its contents and no insert is allowed.

The issue gate is a two-state machine:
- GATE_OPEN: an insert may be taken.
- GATE_COUNT: a wait is being counted down.

The transitions are:
- *arm*: an insert with an issue latency above 1 moves the gate from GATE_OPEN to GATE_COUNT.
- *hold*: a frozen cycle keeps the gate in GATE_COUNT with its count unchanged.
- *tick*: an unfrozen cycle lowers the count.
- *release*: when the count reaches its last step, the gate returns from GATE_COUNT to GATE_OPEN.

Two combinational lookups sit beside the pipe:
- A capability query reports whether the unit executes a given operation class.
- A forwarding query reports whether results from a given source unit may not be forwarded into this one.

Top module: `fu_issue_pipe`

## Requirements
- R1: After reset, out_valid and ins_error are 0, ins_allowed is 1 and cycles_before_insert is 0.
- R2: With no back-pressure, a tag inserted on a clock edge appears on out_tag with out_valid high exactly L edges later, where L is cfg_op_lat clamped to 1..MAX_DEPTH. Tags leave in insertion order, one per insert.
- R3: While out_valid is 1 and out_accept is 0, the pipe is frozen. Every stage, including out_tag, holds its value, and no new tag enters.
- R4: After an insert with issue latency I (a value of 0 is treated as 1), cycles_before_insert reads I-1, I-2, ... 1 on the following unfrozen cycles and then 0. When I is 1, inserts may be taken on back-to-back cycles.
- R5: A frozen cycle does not advance the issue wait. cycles_before_insert keeps its value across it.
- R6: ins_allowed is 1 exactly when cycles_before_insert is 0 and the pipe is not frozen in that cycle.
- R7: An insert presented while ins_allowed is 0 does not enter the pipe and does not restart the issue wait. ins_error is 1 on the cycle after such an attempt and 0 otherwise.
- R8: query_capable is 1 for class code 0 (the no-operation class) always. It is 1 for every class when cfg_class_mask is all zero. Otherwise it equals bit query_class of cfg_class_mask.
- R9: fwd_blocked equals bit fwd_src of cfg_no_fwd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_op_lat | input | LAT_W | Operation latency in stages (1..MAX_DEPTH) |
| cfg_issue_lat | input | ISS_W | Minimum cycles between inserts (0 acts as 1) |
| cfg_class_mask | input | NUM_CLASSES | Supported operation classes, one bit per class |
| cfg_no_fwd | input | NUM_UNITS | Source units that may not forward into this unit |
| query_class | input | CLS_W | Class code for the capability query |
| query_capable | output | 1 | Unit can execute query_class |
| fwd_src | input | UNIT_W | Source unit index for the forwarding query |
| fwd_blocked | output | 1 | Forwarding from fwd_src is not allowed |
| ins_valid | input | 1 | Insert request |
| ins_tag | input | TAG_W | Tag of the operation to insert |
| ins_allowed | output | 1 | An insert this cycle will be taken |
| cycles_before_insert | output | ISS_W | Remaining issue wait in cycles |
| ins_error | output | 1 | The previous cycle attempted a refused insert |
| out_valid | output | 1 | Output stage holds an operation |
| out_tag | output | TAG_W | Tag at the output stage |
| out_accept | input | 1 | Downstream takes the output this cycle |

## Verification
The bench targets several corner cases:
- **Issue wait during a freeze.** A design that let stalled cycles count would reopen insertion early. cycles_before_insert would fall during a hold where it should stay flat.
- **Boundary latencies.** An operation latency of 1 needs a result on the very next edge. The deepest latency exposes an off-by-one stage select. An issue latency of 0 or 1 must allow back-to-back inserts. A wrong decrement shows up as a spurious one-cycle gap or as a missing wait.
- **Refused inserts.** Inserts during a wait or a freeze must neither create phantom outputs nor re-arm the wait. Each must raise exactly one error pulse.
- **Capability decode.** An empty class list and the always-present class 0 are checked separately. A decode that read the mask literally would reject every operation.

// File: rtl/fu_pipe_pkg.sv
package fu_pipe_pkg;

    // Issue-rate gate states
    typedef enum logic [0:0] {
        GATE_OPEN  = 1'b0,
        GATE_COUNT = 1'b1
    } gate_state_e;

    // Class code reserved for operations that need no unit resource
    localparam int unsigned NO_OP_CLASS = 0;

endpackage

// File: rtl/fu_issue_gate.sv
module fu_issue_gate
    import fu_pipe_pkg::*;
#(
    parameter int ISS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ISS_W-1:0] cfg_issue_lat,
    input  logic             take_i,
    input  logic             stall_i,
    output logic             ready_o,
    output logic [ISS_W-1:0] wait_o
);

    gate_state_e      state_q, state_d;
    logic [ISS_W-1:0] cnt_q, cnt_d;
    logic [ISS_W-1:0] lat_m1;

    // A zero issue latency behaves like one: no gap between inserts
    assign lat_m1 = (cfg_issue_lat == '0) ? '0 : cfg_issue_lat - 1'b1;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            GATE_OPEN: begin
                cnt_d = '0;
                if (take_i && lat_m1 != '0) begin
                    state_d = GATE_COUNT;   // arm
                    cnt_d   = lat_m1;
                end
            end
            GATE_COUNT: begin
                if (stall_i) begin
                    cnt_d = cnt_q;          // hold
                end else if (cnt_q <= 1) begin
                    state_d = GATE_OPEN;    // release
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;   // tick
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        ready_o = 1'b0;
        wait_o  = '0;
        unique case (state_q)
            GATE_OPEN:  ready_o = 1'b1;
            GATE_COUNT: wait_o  = cnt_q;
        endcase
    end

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_i && wait_o != '0) |=> (wait_o == $past(wait_o)));

    // R4
    take_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (wait_o == '0));

endmodule

// File: rtl/fu_stage_shift.sv
module fu_stage_shift #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 8,
    localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             push_i,
    input  logic [TAG_W-1:0] push_tag_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             vld_o,
    output logic [TAG_W-1:0] tag_o
);

    logic [DEPTH-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [DEPTH];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_stage
            if (gi == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        vld_q[0] <= 1'b0;
                        tag_q[0] <= '0;
                    end else if (adv_i) begin
                        vld_q[0] <= push_i;
                        tag_q[0] <= push_tag_i;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        vld_q[gi] <= 1'b0;
                        tag_q[gi] <= '0;
                    end else if (adv_i) begin
                        vld_q[gi] <= vld_q[gi-1];
                        tag_q[gi] <= tag_q[gi-1];
                    end
                end
            end
        end
    endgenerate

    assign vld_o = vld_q[sel_i];
    assign tag_o = tag_q[sel_i];

    // R3
    frozen_stages_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(vld_q));

endmodule

// File: rtl/fu_cap_decode.sv
module fu_cap_decode
    import fu_pipe_pkg::*;
#(
    parameter int NUM_CLASSES = 16,
    parameter int NUM_UNITS   = 4,
    localparam int CLS_W  = $clog2(NUM_CLASSES),
    localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic [NUM_CLASSES-1:0] class_mask_i,
    input  logic [CLS_W-1:0]       class_i,
    output logic                   capable_o,
    input  logic [NUM_UNITS-1:0]   no_fwd_i,
    input  logic [UNIT_W-1:0]      src_i,
    output logic                   blocked_o
);

    logic empty_list;
    logic is_noop;

    assign empty_list = (class_mask_i == '0);
    assign is_noop    = (class_i == CLS_W'(NO_OP_CLASS));

    always_comb begin
        capable_o = class_mask_i[class_i];
        if (empty_list || is_noop) capable_o = 1'b1;
    end

    assign blocked_o = no_fwd_i[src_i];

endmodule

// File: rtl/fu_issue_pipe.sv
module fu_issue_pipe
    import fu_pipe_pkg::*;
#(
    parameter int MAX_DEPTH   = 8,
    parameter int TAG_W       = 8,
    parameter int ISS_W       = 4,
    parameter int NUM_CLASSES = 16,
    parameter int NUM_UNITS   = 4,
    localparam int LAT_W  = $clog2(MAX_DEPTH + 1),
    localparam int SEL_W  = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
    localparam int CLS_W  = $clog2(NUM_CLASSES),
    localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LAT_W-1:0]       cfg_op_lat,
    input  logic [ISS_W-1:0]       cfg_issue_lat,
    input  logic [NUM_CLASSES-1:0] cfg_class_mask,
    input  logic [NUM_UNITS-1:0]   cfg_no_fwd,
    input  logic [CLS_W-1:0]       query_class,
    output logic                   query_capable,
    input  logic [UNIT_W-1:0]      fwd_src,
    output logic                   fwd_blocked,
    input  logic                   ins_valid,
    input  logic [TAG_W-1:0]       ins_tag,
    output logic                   ins_allowed,
    output logic [ISS_W-1:0]       cycles_before_insert,
    output logic                   ins_error,
    output logic                   out_valid,
    output logic [TAG_W-1:0]       out_tag,
    input  logic                   out_accept
);

    logic             stalled;
    logic             gate_ready;
    logic             take;
    logic [LAT_W-1:0] lat_m1;
    logic [SEL_W-1:0] stage_sel;
    logic             err_q;

    // Clamp the operation latency to 1..MAX_DEPTH and form a stage index
    always_comb begin
        if (cfg_op_lat == '0)
            lat_m1 = '0;
        else if (cfg_op_lat > LAT_W'(MAX_DEPTH))
            lat_m1 = LAT_W'(MAX_DEPTH - 1);
        else
            lat_m1 = cfg_op_lat - 1'b1;
    end
    assign stage_sel = lat_m1[SEL_W-1:0];

    assign stalled     = out_valid && !out_accept;
    assign ins_allowed = gate_ready && !stalled;
    assign take        = ins_valid && ins_allowed;

    fu_issue_gate #(
        .ISS_W (ISS_W)
    ) gate_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_issue_lat (cfg_issue_lat),
        .take_i        (take),
        .stall_i       (stalled),
        .ready_o       (gate_ready),
        .wait_o        (cycles_before_insert)
    );

    fu_stage_shift #(
        .DEPTH (MAX_DEPTH),
        .TAG_W (TAG_W)
    ) stages_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (!stalled),
        .push_i     (take),
        .push_tag_i (ins_tag),
        .sel_i      (stage_sel),
        .vld_o      (out_valid),
        .tag_o      (out_tag)
    );

    fu_cap_decode #(
        .NUM_CLASSES (NUM_CLASSES),
        .NUM_UNITS   (NUM_UNITS)
    ) cap_i (
        .class_mask_i (cfg_class_mask),
        .class_i      (query_class),
        .capable_o    (query_capable),
        .no_fwd_i     (cfg_no_fwd),
        .src_i        (fwd_src),
        .blocked_o    (fwd_blocked)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= ins_valid && !ins_allowed;
    end
    assign ins_error = err_q;

    // R7
    refused_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_allowed) |=> ins_error);

    // R3
    frozen_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_accept) |=> (out_valid && $stable(out_tag)));

    // R8
    noop_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (query_class == '0) |-> query_capable);

    // R6
    allowed_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_allowed |-> (cycles_before_insert == '0 && !(out_valid && !out_accept)));

endmodule

// File: tb/fu_issue_pipe_tb_top.sv
`timescale 1ns/1ps
module fu_issue_pipe_tb_top;

    localparam int MAX_DEPTH = 8;
    localparam int TAG_W = 8;
    localparam int ISS_W = 4;
    localparam int NCLS = 16;
    localparam int NUN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] cfg_op_lat = 4'd1;
    logic [ISS_W-1:0] cfg_issue_lat = '0;
    logic [NCLS-1:0] cfg_class_mask = '0;
    logic [NUN-1:0] cfg_no_fwd = '0;
    logic [3:0] query_class = '0;
    logic query_capable;
    logic [1:0] fwd_src = '0;
    logic fwd_blocked;
    logic ins_valid = 1'b0;
    logic [TAG_W-1:0] ins_tag = '0;
    logic ins_allowed;
    logic [ISS_W-1:0] cycles_before_insert;
    logic ins_error;
    logic out_valid;
    logic [TAG_W-1:0] out_tag;
    logic out_accept = 1'b1;

    always #4 clk = ~clk;

    fu_issue_pipe dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_op_lat(cfg_op_lat), .cfg_issue_lat(cfg_issue_lat),
        .cfg_class_mask(cfg_class_mask), .cfg_no_fwd(cfg_no_fwd),
        .query_class(query_class), .query_capable(query_capable),
        .fwd_src(fwd_src), .fwd_blocked(fwd_blocked),
        .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_allowed(ins_allowed),
        .cycles_before_insert(cycles_before_insert), .ins_error(ins_error),
        .out_valid(out_valid), .out_tag(out_tag), .out_accept(out_accept)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // Reference model state
    int cyc, next_ins;
    int q_tag[$];
    int q_rem[$];
    bit m_err;
    int cur_lat, cur_iss;
    int tag_ctr;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    task automatic do_reset(input int lat, input int iss);
        @(negedge clk);
        rst_n = 1'b0;
        ins_valid = 1'b0;
        out_accept = 1'b1;
        cfg_op_lat = 4'(lat);
        cfg_issue_lat = ISS_W'(iss);
        cur_lat = (lat < 1) ? 1 : ((lat > MAX_DEPTH) ? MAX_DEPTH : lat);
        cur_iss = (iss < 1) ? 1 : iss;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc = 100;
        next_ins = 0;
        q_tag.delete();
        q_rem.delete();
        m_err = 0;
    endtask

    // One cycle: drive at negedge, compare, then advance the model across the edge
    task automatic step(input bit iv, input bit acc);
        bit m_ov, m_stall, m_open, m_allowed, take;
        int m_tag, m_cbi;
        @(negedge clk);
        ins_valid = iv;
        ins_tag = TAG_W'(tag_ctr);
        out_accept = acc;
        #1;
        m_ov = (q_rem.size() > 0) && (q_rem[0] == 0);
        m_tag = m_ov ? q_tag[0] : 0;
        m_stall = m_ov && !acc;
        m_open = (next_ins == 0) || (cyc >= next_ins);
        m_allowed = m_open && !m_stall;
        m_cbi = m_open ? 0 : next_ins - cyc;
        check(out_valid == m_ov, "R2/R3 out_valid", int'(out_valid), int'(m_ov));
        if (m_ov)
            check(int'(out_tag) == m_tag, "R2/R3 out_tag", int'(out_tag), m_tag);
        check(ins_allowed == m_allowed, "R6 ins_allowed", int'(ins_allowed), int'(m_allowed));
        check(int'(cycles_before_insert) == m_cbi, "R4/R5 cycles_before_insert",
              int'(cycles_before_insert), m_cbi);
        check(ins_error == m_err, "R7 ins_error", int'(ins_error), int'(m_err));
        take = iv && m_allowed;
        m_err = iv && !m_allowed;
        if (!m_stall) begin
            if (m_ov) begin
                void'(q_tag.pop_front());
                void'(q_rem.pop_front());
            end
            foreach (q_rem[k]) if (q_rem[k] > 0) q_rem[k]--;
        end
        if (take) begin
            q_tag.push_back(tag_ctr % 256);
            q_rem.push_back(cur_lat - 1);
            tag_ctr++;
        end
        if (take) next_ins = cyc + cur_iss;
        else if (m_stall && next_ins != 0) next_ins++;
        cyc++;
    endtask

    initial begin
        #(8 * 150000);
        check(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        tag_ctr = 1;
        // R1: reset state
        do_reset(4, 3);
        #1;
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(ins_allowed == 1'b1, "R1 ins_allowed", int'(ins_allowed), 1);
        check(cycles_before_insert == '0, "R1 cycles_before_insert", int'(cycles_before_insert), 0);
        check(ins_error == 1'b0, "R1 ins_error", int'(ins_error), 0);

        // R2, R4: latency 1, back-to-back inserts
        do_reset(1, 1);
        for (int i = 0; i < 30; i++) step(1, 1);
        for (int i = 0; i < 4; i++) step(0, 1);

        // R4: issue latency 0 acts as 1, latency 3
        do_reset(3, 0);
        for (int i = 0; i < 30; i++) step(1, 1);
        for (int i = 0; i < 5; i++) step(0, 1);

        // R4, R7: issue wait 3, inserts attempted every cycle
        do_reset(4, 3);
        for (int i = 0; i < 60; i++) step(1, 1);
        for (int i = 0; i < 6; i++) step(0, 1);

        // R3, R5: long freeze with a wait pending
        do_reset(2, 5);
        step(1, 1);
        step(1, 1);
        step(1, 0);
        for (int i = 0; i < 10; i++) step(1, 0);
        for (int i = 0; i < 20; i++) step(1, 1);
        for (int i = 0; i < 4; i++) step(0, 1);

        // R2, R3, R5, R7: deepest latency, random traffic and back-pressure
        do_reset(MAX_DEPTH, 2);
        for (int i = 0; i < 400; i++) step(1'($urandom_range(0, 1)), ($urandom_range(0, 9) < 7));
        for (int i = 0; i < 12; i++) step(0, 1);

        // R3, R5, R7: mid latency, heavy back-pressure, wait 4
        do_reset(5, 4);
        for (int i = 0; i < 400; i++) step(1'($urandom_range(0, 3) != 0), ($urandom_range(0, 9) < 4));
        for (int i = 0; i < 12; i++) step(0, 1);

        // R8: capability decode, empty list then a sparse list
        cfg_class_mask = '0;
        for (int c = 0; c < NCLS; c++) begin
            query_class = 4'(c);
            #1;
            check(query_capable == 1'b1, "R8 empty list", int'(query_capable), 1);
        end
        cfg_class_mask = 16'h0A50;
        for (int c = 0; c < NCLS; c++) begin
            bit e;
            query_class = 4'(c);
            #1;
            e = (c == 0) ? 1'b1 : cfg_class_mask[c];
            check(query_capable == e, "R8 class list", int'(query_capable), int'(e));
        end

        // R9: forwarding block vector
        cfg_no_fwd = 4'b1001;
        for (int u = 0; u < NUN; u++) begin
            fwd_src = 2'(u);
            #1;
            check(fwd_blocked == cfg_no_fwd[u], "R9 fwd_blocked", int'(fwd_blocked), int'(cfg_no_fwd[u]));
        end
        cfg_no_fwd = 4'b0110;
        for (int u = 0; u < NUN; u++) begin
            fwd_src = 2'(u);
            #1;
            check(fwd_blocked == cfg_no_fwd[u], "R9 fwd_blocked", int'(fwd_blocked), int'(cfg_no_fwd[u]));
        end

        summary();
    end

endmodule